// File: doc/BRIEF.md
# Processor Bus Transfer Sequencer

This block is the processor's side of a shared system bus. It runs one transfer at a time. Each transfer is a memory or I/O read, or a memory or I/O write, and each has a fixed length of two bus cycles. The processor raises `req` for one cycle and gives the direction, the memory-or-I/O choice, the address and the write data with it. The sequencer latches these values and drives the address bus, the write-data bus with its enable, two active-low strobes and the memory/I/O select line. When a transfer ends, `done` goes high for one cycle. After a read, the captured word is on `rdata` during that cycle.

In the first bus cycle the address and the select line are driven and both strobes stay high. This gives the slave time to decode the address. In the second cycle the strobe for the transfer direction goes low. On a write, the data bus is driven in both cycles. On a read, the word on `bus_din` is sampled at the clock edge that ends the strobe cycle. At that same edge the address, data and select outputs return to zero and the strobe goes high again.

Top module: `xfer_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, `rd_n` and `wr_n` are 1, `done` is 0, `bus_dout_oe` is 0, and `bus_addr`, `bus_dout` and `io_m` are 0.
- R2: When `req` is sampled high in the idle state, the latched address is on `bus_addr` in the next cycle (the address cycle), with `rd_n` and `wr_n` both still 1.
- R3: In a read (`wr`=0), `rd_n` is 0 for exactly the one cycle that follows the address cycle (the strobe cycle), and `wr_n` stays 1 throughout.
- R4: For a read, `bus_din` is sampled at the clock edge that ends the strobe cycle. That value is on `rdata` in the `done` cycle, and `rdata` keeps it until the next read captures a new word. Writes leave `rdata` unchanged.
- R5: In a write (`wr`=1), `bus_dout` carries the latched write data and `bus_dout_oe` is 1 in both the address cycle and the strobe cycle. `wr_n` is 0 only in the strobe cycle, and `rd_n` stays 1.
- R6: In the cycle after the strobe cycle, `done` is 1 for exactly one cycle. In that same cycle `bus_addr` is 0, `bus_dout_oe` is 0 and both strobes are 1.
- R7: `io_m` equals the latched `io_sel` (1 = I/O, 0 = memory) throughout the address and strobe cycles. It is 0 when no transfer is running.
- R8: Requests are accepted only in the idle state. A `req` that is held or raised during the address, strobe or done cycle starts nothing. Changes to `addr`, `wdata`, `wr` and `io_sel` during a transfer do not alter the bus outputs.
- R9: `rd_n` and `wr_n` are never 0 at the same time, and `bus_dout_oe` is never 1 while `rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request, sampled in idle |
| wr | input | 1 | 1 = write, 0 = read |
| io_sel | input | 1 | 1 = I/O space, 0 = memory space |
| addr | input | AW | Transfer address |
| wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last word read |
| bus_addr | output | AW | System address bus |
| bus_dout | output | DW | Data bus, outgoing value |
| bus_dout_oe | output | 1 | Data bus output enable |
| bus_din | input | DW | Data bus, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O transfer, 0 = memory transfer |

## Verification
Transfers are drawn at random over direction, space, address, write data and the read word. This separates reads from writes, which use different strobes and a different data-bus enable. It also separates memory from I/O through the select line. Some transfers keep `req` high through the whole sequence, and some invert every processor input right after the request is accepted. These show whether a late request or changed inputs leak onto the bus. Reads placed directly after writes show whether `rdata` is held across them.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;
endpackage

// File: rtl/xseq_ctrl.sv
module xseq_ctrl
    import xseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr,
    input  logic          io_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          done,
    output logic          cap_en
);
    typedef struct packed {
        phase_e        phase;
        logic          is_wr;
        logic          is_io;
        logic [AW-1:0] adr;
        logic [DW-1:0] dat;
        logic          rd_n;
        logic          wr_n;
        logic          done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        phase: PH_IDLE, is_wr: 1'b0, is_io: 1'b0,
        adr: '0, dat: '0, rd_n: 1'b1, wr_n: 1'b1, done: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rd_n = 1'b1;
        ctl_d.wr_n = 1'b1;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req) begin
                    ctl_d.phase = PH_ADDR;
                    ctl_d.is_wr = wr;
                    ctl_d.is_io = io_sel;
                    ctl_d.adr   = addr;
                    ctl_d.dat   = wdata;
                end
            end
            PH_ADDR: begin
                ctl_d.phase = PH_STRB;
                ctl_d.rd_n  = ctl_q.is_wr;
                ctl_d.wr_n  = ~ctl_q.is_wr;
            end
            PH_STRB: begin
                ctl_d.phase = PH_FIN;
                ctl_d.done  = 1'b1;
            end
            default: begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    logic active;
    assign active      = (ctl_q.phase == PH_ADDR) || (ctl_q.phase == PH_STRB);
    assign bus_addr    = active ? ctl_q.adr : '0;
    assign bus_dout_oe = active && ctl_q.is_wr;
    assign bus_dout    = bus_dout_oe ? ctl_q.dat : '0;
    assign io_m        = active && ctl_q.is_io;
    assign rd_n        = ctl_q.rd_n;
    assign wr_n        = ctl_q.wr_n;
    assign done        = ctl_q.done;
    assign cap_en      = (ctl_q.phase == PH_STRB) && !ctl_q.is_wr;
endmodule

// File: rtl/xseq_rcap.sv
module xseq_rcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] word
);
    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (cap_en) word_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr,
    input  logic          io_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m
);
    logic cap_en;

    xseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .io_sel(io_sel),
        .addr(addr), .wdata(wdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_dout_oe(bus_dout_oe), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
        .done(done), .cap_en(cap_en)
    );

    xseq_rcap #(.DW(DW)) u_rcap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .din(bus_din), .word(rdata)
    );
endmodule

// File: rtl/xfer_sequencer_chk.sv
module xfer_sequencer_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          rd_n,
    input logic          wr_n,
    input logic          bus_dout_oe,
    input logic [AW-1:0] bus_addr,
    input logic          io_m
);
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_oe_not_read_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !bus_dout_oe);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n && bus_addr == '0));

    p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> rd_n);

    p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> $stable(bus_addr));

    p_iom_held_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> $stable(io_m));
endmodule

bind xfer_sequencer xfer_sequencer_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .done(done), .rd_n(rd_n), .wr_n(wr_n),
    .bus_dout_oe(bus_dout_oe), .bus_addr(bus_addr), .io_m(io_m)
);

// File: tb/xfer_sequencer_tb.sv
module xfer_sequencer_tb;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic          io_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic          done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_oe;
    logic          rd_n;
    logic          wr_n;
    logic          io_m;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [DW-1:0] last_rd = '0;

    always #2 clk = ~clk;

    xfer_sequencer #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .io_sel(io_sel),
        .addr(addr), .wdata(wdata), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_rdn(input bit w, input int ph);
        return (ph == 2 && !w) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_wrn(input bit w, input int ph);
        return (ph == 2 && w) ? 1'b0 : 1'b1;
    endfunction

    task automatic idle_checks(input string tag);
        chk(rd_n == 1'b1, tag, "rd_n idle", rd_n, 1);
        chk(wr_n == 1'b1, tag, "wr_n idle", wr_n, 1);
        chk(done == 1'b0, tag, "done idle", done, 0);
        chk(bus_dout_oe == 1'b0, tag, "oe idle", bus_dout_oe, 0);
        chk(bus_addr == '0, tag, "bus_addr idle", bus_addr, 0);
        chk(bus_dout == '0, tag, "bus_dout idle", bus_dout, 0);
        chk(io_m == 1'b0, tag, "io_m idle", io_m, 0);
    endtask

    task automatic xfer(input bit w, input bit io, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] din,
                        input bit hold_req, input bit scramble);
        @(negedge clk);
        req = 1'b1; wr = w; io_sel = io; addr = a; wdata = d;
        @(negedge clk);
        // address cycle
        if (!hold_req) req = 1'b0;
        if (scramble) begin
            addr = ~a; wdata = ~d; wr = ~w; io_sel = ~io;
        end
        bus_din = din;
        chk(bus_addr == a, "R2", "addr cycle bus_addr", bus_addr, a);
        chk(rd_n == exp_rdn(w, 1), "R2", "addr cycle rd_n", rd_n, 1);
        chk(wr_n == exp_wrn(w, 1), "R2", "addr cycle wr_n", wr_n, 1);
        chk(io_m == io, "R7", "addr cycle io_m", io_m, io);
        chk(bus_dout_oe == w, "R5", "addr cycle oe", bus_dout_oe, w);
        chk(bus_dout == (w ? d : '0), "R5", "addr cycle dout", bus_dout, w ? d : 0);
        @(negedge clk);
        // strobe cycle
        chk(rd_n == exp_rdn(w, 2), "R3", "strobe rd_n", rd_n, exp_rdn(w, 2));
        chk(wr_n == exp_wrn(w, 2), "R5", "strobe wr_n", wr_n, exp_wrn(w, 2));
        chk(bus_addr == a, "R8", "strobe bus_addr", bus_addr, a);
        chk(io_m == io, "R7", "strobe io_m", io_m, io);
        chk(bus_dout_oe == w, "R9", "strobe oe", bus_dout_oe, w);
        chk(bus_dout == (w ? d : '0), "R5", "strobe dout", bus_dout, w ? d : 0);
        chk(done == 1'b0, "R6", "done early", done, 0);
        @(negedge clk);
        // done cycle
        bus_din = DW'($urandom);
        if (!w) last_rd = din;
        chk(done == 1'b1, "R6", "done pulse", done, 1);
        chk(bus_addr == '0, "R6", "addr released", bus_addr, 0);
        chk(bus_dout_oe == 1'b0, "R6", "oe released", bus_dout_oe, 0);
        chk(rd_n && wr_n, "R6", "strobes high", {rd_n, wr_n}, 3);
        chk(io_m == 1'b0, "R7", "io_m after", io_m, 0);
        chk(rdata == last_rd, "R4", "rdata", rdata, last_rd);
        @(negedge clk);
        // back in idle; a held request must not have started a transfer
        chk(done == 1'b0, "R6", "done one cycle", done, 0);
        chk(bus_addr == '0 && rd_n && wr_n, "R8", "no restart from held req",
            bus_addr, 0);
        chk(rdata == last_rd, "R4", "rdata held", rdata, last_rd);
        req = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        idle_checks("R1");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        idle_checks("R1");

        // directed corners
        xfer(1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5, 1'b0, 1'b0);
        xfer(1'b1, 1'b1, 16'hFFFF, 8'h3C, 8'h11, 1'b0, 1'b0);
        xfer(1'b0, 1'b1, 16'h0001, 8'h00, 8'h5A, 1'b1, 1'b1);
        xfer(1'b1, 1'b0, 16'h8000, 8'hFF, 8'h77, 1'b1, 1'b1);
        xfer(1'b0, 1'b0, 16'h0000, 8'h00, 8'hFF, 1'b0, 1'b1);

        // random traffic
        for (int i = 0; i < 60; i++) begin
            xfer(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
                 DW'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                idle_checks("R8");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule